// File: doc/BRIEF.md
# CAN Receive Frame FIFO with Byte Window

This block holds received CAN frames in a small first-in first-out store and shows the oldest one to a host as a window of thirteen bytes. Each byte sits in its own 32-bit word. A protocol engine hands over each complete frame in one cycle: the identifier, the extended-format and remote flags, the DLC and up to eight data bytes. At that point the block packs the frame into the window byte layout. The position of the data bytes depends on whether the identifier is 11 or 29 bits wide.

The host reads the window with a word address, and the read data comes back in the same cycle. A release pulse throws away the oldest frame and brings the next one into the window. The host sees a ready flag and the number of stored frames. If a frame arrives while the store is full, that frame is dropped and a sticky overrun flag is set, together with a one-cycle overrun event. A separate pulse clears the overrun flag. Each accepted frame also produces a one-cycle stored pulse, which a register unit can turn into a receive interrupt.

Top module: `can_rx_fifo_window`

## Requirements
- R1: A read at word address 0x40 + 4*n, for n from 0 to 12, returns byte n of the oldest stored frame in the same cycle. Any other address, and any read while nothing is stored, returns 0x00.
- R2: Byte 0 holds the frame information: bit 7 is the extended-format flag, bit 6 is the remote flag, bits 5:4 are zero and bits 3:0 hold the DLC exactly as received.
- R3: For an 11-bit identifier, byte 1 is ID[10:3] and byte 2 is {ID[2:0], 5'b0}. Data starts at byte 3.
- R4: For a 29-bit identifier, bytes 1, 2 and 3 are ID[28:21], ID[20:13] and ID[12:5], and byte 4 is {ID[4:0], 3'b0}. Data starts at byte 5.
- R5: A data frame stores min(DLC, 8) data bytes, with input byte i (bits 8i+7:8i of the data input) at the i-th data position. A remote frame stores no data bytes. Every window byte that holds no field reads 0x00.
- R6: After reset the count is 0 and ready and overrun are low. The count always equals the number of stored frames, at most DEPTH, and ready is high exactly when the count is nonzero.
- R7: A release pulse removes the oldest frame; the change is visible from the next cycle. A release while the store is empty has no effect. A frame write and a release in the same cycle on a non-empty, non-full store leave the count unchanged.
- R8: A frame that arrives while the count equals DEPTH is dropped, even if a release is given in the same cycle. The stored frames stay unchanged.
- R9: A dropped frame sets the overrun flag and raises the overrun event for exactly one cycle, both in the following cycle. The flag holds until a clear pulse. If a drop and a clear come in the same cycle, the flag stays set.
- R10: Each accepted frame raises the stored pulse for exactly one cycle, in the following cycle. A dropped frame does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | Frame from the protocol engine, valid for one cycle |
| fr_ext | input | 1 | Frame uses a 29-bit identifier |
| fr_rtr | input | 1 | Frame is a remote frame |
| fr_id | input | 29 | Identifier; bits 10:0 are used for 11-bit frames |
| fr_dlc | input | 4 | Data length code |
| fr_data | input | 64 | Data bytes; byte i is in bits 8i+7:8i |
| host_addr | input | ADDR_W | Word address of the read |
| host_rdata | output | 8 | Window byte at host_addr |
| host_release | input | 1 | Discard the oldest frame |
| host_clr_ovr | input | 1 | Clear the overrun flag |
| rx_ready | output | 1 | At least one frame is stored |
| rx_count | output | $clog2(DEPTH+1) | Number of stored frames |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_evt | output | 1 | One-cycle pulse when a frame is dropped |
| rx_stored | output | 1 | One-cycle pulse when a frame is accepted |

## Verification
A wrong read or write pointer shows up at once: the window then holds a frame other than the oldest, which is visible at the first read after the next write or release. A wrong count shows on rx_count and rx_ready in the cycle after the update that caused it, and it also moves the point at which frames start to be dropped, which the overrun outputs reveal. A packing error stays hidden until the host reads the affected byte. For that reason the host address sweeps the whole window and its edges on every cycle, and each cycle's result is compared with a queue model.

// File: rtl/can_rx_fifo_window.sv
module can_rx_fifo_window #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fr_valid,
  input  logic                         fr_ext,
  input  logic                         fr_rtr,
  input  logic [28:0]                  fr_id,
  input  logic [3:0]                   fr_dlc,
  input  logic [63:0]                  fr_data,
  input  logic [ADDR_W-1:0]            host_addr,
  output logic [7:0]                   host_rdata,
  input  logic                         host_release,
  input  logic                         host_clr_ovr,
  output logic                         rx_ready,
  output logic [$clog2(DEPTH+1)-1:0]   rx_count,
  output logic                         ovr_flag,
  output logic                         ovr_evt,
  output logic                         rx_stored
);
  localparam int NB = 13;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(4 * NB);

  logic [7:0]    mem [DEPTH][NB];
  logic [7:0]    pk  [NB];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic [3:0]    nd;

  wire full  = cnt == CW'(DEPTH);
  wire empty = cnt == '0;
  wire acc   = fr_valid && !full;
  wire pop   = host_release && !empty;

  always_comb begin
    nd = fr_rtr ? 4'd0 : ((fr_dlc > 4'd8) ? 4'd8 : fr_dlc);
    for (int b = 0; b < NB; b++) pk[b] = '0;
    pk[0] = {fr_ext, fr_rtr, 2'b00, fr_dlc};
    if (fr_ext) begin
      pk[1] = fr_id[28:21];
      pk[2] = fr_id[20:13];
      pk[3] = fr_id[12:5];
      pk[4] = {fr_id[4:0], 3'b000};
    end else begin
      pk[1] = fr_id[10:3];
      pk[2] = {fr_id[2:0], 5'b00000};
    end
    for (int i = 0; i < 8; i++)
      if (4'(i) < nd) pk[(fr_ext ? 5 : 3) + i] = fr_data[8*i +: 8];
  end

  wire [ADDR_W-1:0] off = host_addr - WIN_BASE;
  wire [3:0]        idx = off[5:2];
  wire hit = (host_addr >= WIN_BASE) && (off < WIN_SPAN) && (host_addr[1:0] == 2'b00);

  assign host_rdata = (hit && !empty) ? mem[rp][idx] : 8'h00;
  assign rx_ready   = !empty;
  assign rx_count   = cnt;

  always_ff @(posedge clk) begin
    if (acc)
      for (int b = 0; b < NB; b++) mem[wp][b] <= pk[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp        <= '0;
      wp        <= '0;
      cnt       <= '0;
      ovr_flag  <= 1'b0;
      ovr_evt   <= 1'b0;
      rx_stored <= 1'b0;
    end else begin
      if (acc) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt       <= cnt + CW'(acc) - CW'(pop);
      ovr_evt   <= fr_valid && full;
      rx_stored <= acc;
      if (fr_valid && full) ovr_flag <= 1'b1;
      else if (host_clr_ovr) ovr_flag <= 1'b0;
    end
  end
endmodule

module can_rx_fifo_window_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fr_valid,
  input logic          host_release,
  input logic          host_clr_ovr,
  input logic [7:0]    host_rdata,
  input logic [CW-1:0] rx_count,
  input logic          ovr_flag,
  input logic          ovr_evt,
  input logic          rx_stored
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= FULL);

  assert_empty_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == '0 |-> host_rdata == 8'h00);

  assert_release_pops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_release && !fr_valid && rx_count != '0 |=> rx_count == $past(rx_count) - 1'b1);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && rx_count == FULL |=> rx_count == $past(rx_count) - CW'($past(host_release)) && !rx_stored);

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !host_clr_ovr |=> ovr_flag);

  assert_ovr_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && rx_count == FULL |=> ovr_evt && ovr_flag);

  assert_store_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && rx_count != FULL && !host_release |=> rx_stored && rx_count == $past(rx_count) + 1'b1);

  assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_stored && ovr_evt));
endmodule

bind can_rx_fifo_window can_rx_fifo_window_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .host_release(host_release),
  .host_clr_ovr(host_clr_ovr), .host_rdata(host_rdata), .rx_count(rx_count),
  .ovr_flag(ovr_flag), .ovr_evt(ovr_evt), .rx_stored(rx_stored)
);

// File: tb/can_rx_fifo_window_test.sv
module can_rx_fifo_window_test;
  localparam int DEPTH = 4;
  localparam int AW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fr_valid = 0, fr_ext = 0, fr_rtr = 0;
  logic [28:0] fr_id = '0;
  logic [3:0]  fr_dlc = '0;
  logic [63:0] fr_data = '0;
  logic [AW-1:0] host_addr = '0;
  logic host_release = 0, host_clr_ovr = 0;
  logic [7:0] host_rdata;
  logic rx_ready, ovr_flag, ovr_evt, rx_stored;
  logic [CW-1:0] rx_count;

  can_rx_fifo_window #(.DEPTH(DEPTH), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_ext(fr_ext), .fr_rtr(fr_rtr),
    .fr_id(fr_id), .fr_dlc(fr_dlc), .fr_data(fr_data), .host_addr(host_addr),
    .host_rdata(host_rdata), .host_release(host_release), .host_clr_ovr(host_clr_ovr),
    .rx_ready(rx_ready), .rx_count(rx_count), .ovr_flag(ovr_flag), .ovr_evt(ovr_evt),
    .rx_stored(rx_stored)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit started = 0, done = 0;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [103:0] pack(bit ext, bit rtr, logic [28:0] id, logic [3:0] dlc, logic [63:0] d);
    logic [103:0] f = '0;
    int base, n;
    f[7:0] = {ext, rtr, 2'b00, dlc};
    if (ext) begin
      f[15:8] = id[28:21]; f[23:16] = id[20:13]; f[31:24] = id[12:5]; f[39:32] = {id[4:0], 3'b000};
      base = 5;
    end else begin
      f[15:8] = id[10:3]; f[23:16] = {id[2:0], 5'b00000};
      base = 3;
    end
    n = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
    for (int i = 0; i < n; i++) f[8*(base+i) +: 8] = d[8*i +: 8];
    return f;
  endfunction

  // behavioural reference model
  logic [103:0] mq[$];
  bit m_ovr = 0, m_evt = 0, m_st = 0, m_full = 0;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mq.delete(); m_ovr = 0; m_evt = 0; m_st = 0;
    end else begin
      m_full = (mq.size() == DEPTH);
      m_evt  = fr_valid && m_full;
      m_st   = fr_valid && !m_full;
      if (m_evt) m_ovr = 1; else if (host_clr_ovr) m_ovr = 0;
      if (host_release && mq.size() > 0) void'(mq.pop_front());
      if (m_st) mq.push_back(pack(fr_ext, fr_rtr, fr_id, fr_dlc, fr_data));
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      int a, n, exp, lo;
      logic [103:0] h;
      string tag;
      check("R6 count", int'(rx_count), mq.size());
      check("R6 ready", int'(rx_ready), int'(mq.size() != 0));
      check("R9 overrun flag", int'(ovr_flag), int'(m_ovr));
      check("R9 overrun event", int'(ovr_evt), int'(m_evt));
      check("R10 stored pulse", int'(rx_stored), int'(m_st));
      a = int'(host_addr);
      exp = 0; tag = "R1 window";
      if (mq.size() != 0 && a >= 'h40 && a % 4 == 0 && (a - 'h40) / 4 <= 12) begin
        n = (a - 'h40) / 4;
        h = mq[0];
        exp = int'(h[8*n +: 8]);
        lo = h[7] ? 5 : 3;
        if (n == 0) tag = "R2 info byte";
        else if (n >= lo) tag = "R5 data byte";
        else tag = h[7] ? "R4 extended id" : "R3 standard id";
      end
      check(tag, int'(host_rdata), exp);
    end
  end

  // address sweep across the window and its edges, misaligned ones included
  int sweep = 'h3C;
  always @(posedge clk) begin
    #3;
    host_addr = AW'(sweep);
    sweep = (sweep >= 'h77) ? 'h3C : sweep + 1;
  end

  task automatic step();
    @(posedge clk); #2;
    fr_valid = 0; host_release = 0; host_clr_ovr = 0;
  endtask

  task automatic send(bit ext, bit rtr, logic [28:0] id, logic [3:0] dlc, logic [63:0] d, bit rel = 0, bit clr = 0);
    fr_valid = 1; fr_ext = ext; fr_rtr = rtr; fr_id = id; fr_dlc = dlc; fr_data = d;
    host_release = rel; host_clr_ovr = clr;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    step(); step(); step();
    check("R6 reset count", int'(rx_count), 0);
    check("R6 reset ready", int'(rx_ready), 0);
    check("R9 reset overrun", int'(ovr_flag), 0);
    rst_n = 1;
    step();
    send(0, 0, 29'h5A3, 4'd3, 64'h0000_0000_00CC_BBAA);         // R3 standard, R5 three bytes
    idle(60);
    send(1, 0, 29'h1ABC_DE12, 4'd8, 64'h8877_6655_4433_2211);   // R4 extended, full data
    send(1, 1, 29'h0123_4567, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF);   // R5 remote: no data
    send(0, 0, 29'h7FF, 4'd15, 64'h0102_0304_0506_0708);        // R2 raw DLC 15, R5 clamp to 8
    check("R6 count at full", int'(rx_count), 4);
    idle(60);
    send(0, 0, 29'h111, 4'd2, 64'h0000_0000_0000_DEAD);         // R8 dropped
    check("R8 count after drop", int'(rx_count), 4);
    check("R9 flag after drop", int'(ovr_flag), 1);
    idle(60);                                                    // R8 head still the first frame
    send(0, 0, 29'h222, 4'd1, 64'h55, 0, 1);                     // R9 set wins over clear
    check("R9 set over clear", int'(ovr_flag), 1);
    host_clr_ovr = 1; step();
    check("R9 cleared", int'(ovr_flag), 0);
    send(0, 0, 29'h333, 4'd1, 64'h66, 1, 0);                     // R8 drop despite release
    check("R8 full with release", int'(rx_count), 3);
    check("R9 flag full with release", int'(ovr_flag), 1);
    idle(60);
    host_release = 1; step();
    host_release = 1; step();
    host_release = 1; step();
    check("R7 count drained", int'(rx_count), 0);
    host_release = 1; step();                                    // R7 release on empty
    check("R7 release on empty", int'(rx_count), 0);
    send(1, 0, 29'h1FFF_FFFF, 4'd0, 64'h0, 1, 0);                // R7 write+release on empty
    check("R7 write with release on empty", int'(rx_count), 1);
    send(0, 0, 29'h444, 4'd4, 64'hAABB_CCDD, 1, 0);              // R7 write+release non-empty
    check("R7 write with release", int'(rx_count), 1);
    idle(60);
    for (int i = 0; i < 4000; i++) begin
      fr_valid = ($urandom % 3) == 0;
      fr_ext = $urandom % 2; fr_rtr = ($urandom % 5) == 0;
      fr_id = 29'($urandom); fr_dlc = 4'($urandom);
      fr_data = {$urandom, $urandom};
      host_release = ($urandom % 4) == 0;
      host_clr_ovr = ($urandom % 16) == 0;
      @(posedge clk); #2;
      fr_valid = 0; host_release = 0; host_clr_ovr = 0;
    end
    idle(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule